// File: doc/BRIEF.md
# Prime Implicant Cover Selector

This block takes a list of up to sixteen product terms (cubes) over four input variables, each with a valid bit, together with a 16-bit on-set. It selects a small subset of the cubes whose union covers every on-set minterm. It is meant to follow a prime-implicant generator in a two-level logic minimiser. A one-cycle `start` pulse captures the inputs into a register-held cover table. Rows are cubes and columns are minterms. The block then reduces the table one step per clock until no column is left.

The controller has six states. `PC_IDLE` waits for `start`. It moves to `PC_ESSEN` when at least one coverable on-set minterm exists, and to `PC_FINISH` otherwise. `PC_ESSEN` does one of three things:

- If no column is left, it moves to `PC_FINISH`.
- If any column has exactly one mark, it adds those rows to the cover, removes the columns they reach and stays in `PC_ESSEN`.
- Otherwise it moves to `PC_ROWDOM`.

`PC_ROWDOM` deletes dominated rows and returns to `PC_ESSEN`. If there is nothing to delete, it moves to `PC_COLDOM`. `PC_COLDOM` deletes dominating columns and returns to `PC_ESSEN`. If there is nothing to delete, it moves to `PC_CYCLIC`. `PC_CYCLIC` forces one row into the cover and returns to `PC_ESSEN`. `PC_FINISH` raises `done` for one cycle and returns to `PC_IDLE`.

Cube k uses bits `[4k+3:4k]` of both `cube_val` and `cube_care`. A care bit of 1 means that variable appears as a literal, with the polarity given by the value bit. Minterm m is covered when `((m ^ val) & care) == 0`, where bit v of m is variable v. The cost of a row is its literal count, which is the number of care bits set. Rows are ranked by cost first and then by index.

Top module: `prime_cover_select`

## Requirements
- R1: While reset is held and after reset is released, `busy`, `done` and `select` are all 0.
- R2: A cube whose `cube_ok` bit is 0 at `start` never enters the table. Its `select` bit stays 0, and it changes no other selection bit.
- R3: On-set minterms that no valid cube covers are dropped from the table. When no coverable on-set minterm remains, `done` rises in the first cycle after `start` and `select` is 0.
- R4: A column with a single live mark makes its row essential. That row is added to the cover and every column it covers is removed. The step repeats while new essential rows appear.
- R5: Row P is deleted when another live row Q covers every live column that P covers and Q costs no more than P. An exact tie in both coverage and cost keeps the lower index. A row with no live marks is deleted.
- R6: Column i is deleted when another live column j has its marks only in rows where i also has marks. Of two equal columns, the lower index is kept.
- R7: In a cyclic table, the row with the fewest literals (lowest index on ties) that covers at least one live column is added to the cover.
- R8: `done` is a one-cycle pulse. `select` then names cubes whose union equals the coverable on-set and none of which reaches outside the on-set. `select` holds its value until the next accepted `start`.
- R9: Each table step takes exactly one clock, and `busy` is 1 from the cycle after `start` until `done`.
- R10: `start` is ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the inputs and begin (only in idle) |
| cube_val | input | NCUBE*NVAR | Literal polarity per cube |
| cube_care | input | NCUBE*NVAR | Literal present per cube |
| cube_ok | input | NCUBE | Cube valid bits |
| onset | input | 2**NVAR | Minterms to cover |
| busy | output | 1 | Table reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| select | output | NCUBE | Chosen cubes |

## Verification
The bench builds the block with its default parameters, four variables and sixteen cubes. This gives the full sixteen-row table, so cost ranking, index tie-breaks and all sixteen columns are reachable.

A behavioural model replays the reduction step by step. It predicts both the final selection and the exact cycle of `done`, and the bench compares `done` and `busy` against the model on every clock.

The directed cases are:
- the seven-prime textbook table, which passes through an essential row, a cyclic break and two row deletions;
- a permuted copy of that table, which separates rank from index;
- invalid and uncoverable inputs;
- an empty on-set;
- a start pulse issued while busy.

Random cube lists then reach column dominance and deeper cyclic chains.

// File: rtl/prime_cover_pkg.sv
package prime_cover_pkg;
    typedef enum logic [2:0] {
        PC_IDLE,
        PC_ESSEN,
        PC_ROWDOM,
        PC_COLDOM,
        PC_CYCLIC,
        PC_FINISH
    } pc_state_t;
endpackage

// File: rtl/pc_table_build.sv
module pc_table_build #(
    parameter int NVAR  = 4,
    parameter int NCUBE = 16
) (
    input  logic [NCUBE*NVAR-1:0]                    cube_val,
    input  logic [NCUBE*NVAR-1:0]                    cube_care,
    output logic [NCUBE-1:0][(1<<NVAR)-1:0]          cov,
    output logic [NCUBE-1:0][$clog2(NVAR+1)-1:0]     lits
);
    localparam int NMINT = 1 << NVAR;
    localparam int LW    = $clog2(NVAR + 1);

    for (genvar r = 0; r < NCUBE; r++) begin : g_row
        logic [NVAR-1:0] v_r;
        logic [NVAR-1:0] c_r;
        assign v_r     = cube_val[r*NVAR +: NVAR];
        assign c_r     = cube_care[r*NVAR +: NVAR];
        assign lits[r] = LW'($countones(c_r));
        for (genvar m = 0; m < NMINT; m++) begin : g_col
            localparam logic [NVAR-1:0] MV = NVAR'(m);
            assign cov[r][m] = ((MV ^ v_r) & c_r) == '0;
        end
    end
endmodule

// File: rtl/pc_essential.sv
module pc_essential #(
    parameter int NVAR  = 4,
    parameter int NCUBE = 16
) (
    input  logic [NCUBE-1:0][(1<<NVAR)-1:0] mark,
    input  logic [(1<<NVAR)-1:0]            live_col,
    output logic [NCUBE-1:0]                ess
);
    localparam int NMINT = 1 << NVAR;

    logic [NMINT-1:0][NCUBE-1:0] colm;
    logic [NMINT-1:0]            single;

    always_comb begin
        for (int c = 0; c < NMINT; c++) begin
            for (int r = 0; r < NCUBE; r++) begin
                colm[c][r] = mark[r][c];
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NMINT; c++) begin
            single[c] = live_col[c] && (colm[c] != '0) &&
                        ((colm[c] & (colm[c] - 1'b1)) == '0);
        end
    end

    always_comb begin
        ess = '0;
        for (int c = 0; c < NMINT; c++) begin
            if (single[c]) ess = ess | colm[c];
        end
    end
endmodule

// File: rtl/pc_dominance.sv
module pc_dominance #(
    parameter int NVAR  = 4,
    parameter int NCUBE = 16
) (
    input  logic [NCUBE-1:0][(1<<NVAR)-1:0]      mark,
    input  logic [NCUBE-1:0][$clog2(NVAR+1)-1:0] lits,
    input  logic [NCUBE-1:0]                     live_row,
    input  logic [(1<<NVAR)-1:0]                 live_col,
    output logic [NCUBE-1:0]                     row_del,
    output logic [(1<<NVAR)-1:0]                 col_del
);
    localparam int NMINT = 1 << NVAR;

    logic [NMINT-1:0][NCUBE-1:0] colm;

    always_comb begin
        for (int c = 0; c < NMINT; c++) begin
            for (int r = 0; r < NCUBE; r++) begin
                colm[c][r] = mark[r][c];
            end
        end
    end

    // Row P goes when a live row at least as cheap covers all of P's columns.
    always_comb begin
        row_del = '0;
        for (int p = 0; p < NCUBE; p++) begin
            if (live_row[p]) begin
                if (mark[p] == '0) row_del[p] = 1'b1;
                for (int q = 0; q < NCUBE; q++) begin
                    if (q != p && live_row[q] &&
                        ((mark[p] & ~mark[q]) == '0) &&
                        ((lits[q] < lits[p]) ||
                         ((lits[q] == lits[p]) &&
                          ((mark[q] != mark[p]) || (q < p))))) begin
                        row_del[p] = 1'b1;
                    end
                end
            end
        end
    end

    // Column i goes when a live column's rows are a subset of i's rows.
    always_comb begin
        col_del = '0;
        for (int i = 0; i < NMINT; i++) begin
            if (live_col[i]) begin
                for (int j = 0; j < NMINT; j++) begin
                    if (j != i && live_col[j] &&
                        ((colm[j] & ~colm[i]) == '0) &&
                        ((colm[j] != colm[i]) || (j < i))) begin
                        col_del[i] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/pc_pick.sv
module pc_pick #(
    parameter int NVAR  = 4,
    parameter int NCUBE = 16
) (
    input  logic [NCUBE-1:0][(1<<NVAR)-1:0]      mark,
    input  logic [NCUBE-1:0][$clog2(NVAR+1)-1:0] lits,
    output logic [NCUBE-1:0]                     pick
);
    localparam int LW = $clog2(NVAR + 1);

    logic found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int l = 0; l <= NVAR; l++) begin
            for (int r = 0; r < NCUBE; r++) begin
                if (!found && (lits[r] == LW'(l)) && (mark[r] != '0)) begin
                    pick[r] = 1'b1;
                    found   = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/prime_cover_select.sv
module prime_cover_select
    import prime_cover_pkg::*;
#(
    parameter int NVAR  = 4,
    parameter int NCUBE = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [NCUBE*NVAR-1:0]      cube_val,
    input  logic [NCUBE*NVAR-1:0]      cube_care,
    input  logic [NCUBE-1:0]           cube_ok,
    input  logic [(1<<NVAR)-1:0]       onset,
    output logic                       busy,
    output logic                       done,
    output logic [NCUBE-1:0]           select
);
    localparam int NMINT = 1 << NVAR;
    localparam int LW    = $clog2(NVAR + 1);

    pc_state_t state, state_nx;

    logic [NCUBE-1:0][NMINT-1:0] cov_in, cov_q, mark;
    logic [NCUBE-1:0][LW-1:0]    lits_in, lits_q;
    logic [NCUBE-1:0]            live_row, sel, ok_q;
    logic [NMINT-1:0]            live_col, reach_in, col_any;
    logic [NCUBE-1:0]            ess, row_del, pick;
    logic [NMINT-1:0]            col_del, ess_cols, pick_cols;

    pc_table_build #(.NVAR(NVAR), .NCUBE(NCUBE)) u_build (
        .cube_val (cube_val),
        .cube_care(cube_care),
        .cov      (cov_in),
        .lits     (lits_in)
    );

    always_comb begin
        reach_in = '0;
        for (int r = 0; r < NCUBE; r++) begin
            if (cube_ok[r]) reach_in = reach_in | cov_in[r];
        end
    end

    always_comb begin
        col_any = '0;
        for (int r = 0; r < NCUBE; r++) begin
            mark[r] = live_row[r] ? (cov_q[r] & live_col) : '0;
            col_any = col_any | mark[r];
        end
    end

    pc_essential #(.NVAR(NVAR), .NCUBE(NCUBE)) u_ess (
        .mark    (mark),
        .live_col(live_col),
        .ess     (ess)
    );

    pc_dominance #(.NVAR(NVAR), .NCUBE(NCUBE)) u_dom (
        .mark    (mark),
        .lits    (lits_q),
        .live_row(live_row),
        .live_col(live_col),
        .row_del (row_del),
        .col_del (col_del)
    );

    pc_pick #(.NVAR(NVAR), .NCUBE(NCUBE)) u_pick (
        .mark(mark),
        .lits(lits_q),
        .pick(pick)
    );

    always_comb begin
        ess_cols  = '0;
        pick_cols = '0;
        for (int r = 0; r < NCUBE; r++) begin
            if (ess[r])  ess_cols  = ess_cols  | cov_q[r];
            if (pick[r]) pick_cols = pick_cols | cov_q[r];
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PC_IDLE;
        else        state <= state_nx;
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            PC_IDLE:   if (start) state_nx = ((onset & reach_in) == '0) ? PC_FINISH : PC_ESSEN;
            PC_ESSEN:  if (live_col == '0)  state_nx = PC_FINISH;
                       else if (ess == '0)  state_nx = PC_ROWDOM;
            PC_ROWDOM: state_nx = (row_del != '0) ? PC_ESSEN : PC_COLDOM;
            PC_COLDOM: state_nx = (col_del != '0) ? PC_ESSEN : PC_CYCLIC;
            PC_CYCLIC: state_nx = PC_ESSEN;
            PC_FINISH: state_nx = PC_IDLE;
            default:   state_nx = PC_IDLE;
        endcase
    end

    // Cover table and selection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cov_q    <= '0;
            lits_q   <= '0;
            ok_q     <= '0;
            live_row <= '0;
            live_col <= '0;
            sel      <= '0;
        end else begin
            unique case (state)
                PC_IDLE: if (start) begin
                    cov_q    <= cov_in;
                    lits_q   <= lits_in;
                    ok_q     <= cube_ok;
                    live_row <= cube_ok;
                    live_col <= onset & reach_in;
                    sel      <= '0;
                end
                PC_ESSEN: if (live_col != '0 && ess != '0) begin
                    sel      <= sel | ess;
                    live_row <= live_row & ~ess;
                    live_col <= live_col & ~ess_cols;
                end
                PC_ROWDOM: live_row <= live_row & ~row_del;
                PC_COLDOM: live_col <= live_col & ~col_del;
                PC_CYCLIC: begin
                    sel      <= sel | pick;
                    live_row <= live_row & ~pick;
                    live_col <= live_col & ~pick_cols;
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy   = (state == PC_ESSEN) || (state == PC_ROWDOM) ||
                 (state == PC_COLDOM) || (state == PC_CYCLIC);
        done   = (state == PC_FINISH);
        select = sel;
    end

    a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r6_live_col_marked: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ((live_col & ~col_any) == '0));

    a_r7_pick_single: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PC_CYCLIC) |-> ($countones(pick) == 1));

    a_r5_row_survivor: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PC_ROWDOM && live_col != '0) |-> ((live_row & ~row_del) != '0));

    a_r2_sel_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (sel & ~ok_q) == '0);

    a_r4_sel_grows: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ((sel & $past(sel)) == $past(sel)));

    a_r10_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> $stable(ok_q));
endmodule

// File: tb/prime_cover_select_bench.sv
module prime_cover_select_bench;
    localparam int NVAR  = 4;
    localparam int NCUBE = 16;

    logic        clk = 1'b0;
    logic        rst_n, start;
    logic [63:0] cval, ccare;
    logic [15:0] cok, onset;
    logic        busy, done;
    logic [15:0] sel;
    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    prime_cover_select #(.NVAR(NVAR), .NCUBE(NCUBE)) u_prime_cover_select (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cube_val(cval), .cube_care(ccare), .cube_ok(cok), .onset(onset),
        .busy(busy), .done(done), .select(sel)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] cube_cov(input logic [3:0] v, input logic [3:0] c);
        logic [15:0] m;
        m = '0;
        for (int i = 0; i < 16; i++) begin
            logic [3:0] mi;
            mi = 4'(i);
            if (((mi ^ v) & c) == 4'b0) m[i] = 1'b1;
        end
        return m;
    endfunction

    // Behavioural reference: replays the reduction, one step per clock.
    task automatic model_run(input logic [63:0] v, input logic [63:0] c,
                             input logic [15:0] ok, input logic [15:0] on,
                             output logic [15:0] esel, output int n,
                             output logic [15:0] reach);
        logic [15:0] cv[16];
        logic [15:0] rm[16];
        logic [15:0] cm[16];
        int          lt[16];
        logic [15:0] lr, lc, ess, del, cols;
        int          st;
        bit          found;
        reach = '0;
        for (int r = 0; r < 16; r++) begin
            cv[r] = cube_cov(v[r*4 +: 4], c[r*4 +: 4]);
            lt[r] = $countones(c[r*4 +: 4]);
            if (ok[r]) reach |= cv[r];
        end
        lr = ok; lc = on & reach; esel = '0; n = 0; st = 1;
        if (lc == '0) return;
        while (n < 2000) begin
            n++;
            for (int r = 0; r < 16; r++) rm[r] = lr[r] ? (cv[r] & lc) : 16'h0;
            for (int k = 0; k < 16; k++)
                for (int r = 0; r < 16; r++) cm[k][r] = rm[r][k];
            case (st)
                1: begin
                    if (lc == '0) return;
                    ess = '0;
                    for (int k = 0; k < 16; k++)
                        if (lc[k] && $countones(cm[k]) == 1) ess |= cm[k];
                    if (ess != '0) begin
                        cols = '0;
                        for (int r = 0; r < 16; r++) if (ess[r]) cols |= cv[r];
                        esel |= ess; lr &= ~ess; lc &= ~cols;
                    end else st = 2;
                end
                2: begin
                    del = '0;
                    for (int p = 0; p < 16; p++) if (lr[p]) begin
                        if (rm[p] == '0) del[p] = 1'b1;
                        for (int q = 0; q < 16; q++)
                            if (q != p && lr[q] && (rm[p] & ~rm[q]) == '0 &&
                                (lt[q] < lt[p] || (lt[q] == lt[p] && (rm[q] != rm[p] || q < p))))
                                del[p] = 1'b1;
                    end
                    if (del != '0) begin lr &= ~del; st = 1; end else st = 3;
                end
                3: begin
                    del = '0;
                    for (int i = 0; i < 16; i++) if (lc[i])
                        for (int j = 0; j < 16; j++)
                            if (j != i && lc[j] && (cm[j] & ~cm[i]) == '0 &&
                                (cm[j] != cm[i] || j < i))
                                del[i] = 1'b1;
                    if (del != '0) begin lc &= ~del; st = 1; end else st = 4;
                end
                default: begin
                    found = 1'b0;
                    for (int l = 0; l <= 4; l++)
                        for (int r = 0; r < 16; r++)
                            if (!found && lt[r] == l && rm[r] != '0) begin
                                found = 1'b1; esel[r] = 1'b1; lr[r] = 1'b0; lc &= ~cv[r];
                            end
                    st = 1;
                end
            endcase
        end
    endtask

    // Drive one problem, compare done/busy every clock, then check the result.
    task automatic run_case(input string tag, input logic [63:0] v, input logic [63:0] c,
                            input logic [15:0] ok, input logic [15:0] on,
                            input bit poke, output logic [15:0] got);
        logic [15:0] esel, reach, uni;
        int n;
        bit sub;
        model_run(v, c, ok, on, esel, n, reach);
        @(negedge clk);
        cval = v; ccare = c; cok = ok; onset = on; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k <= n; k++) begin
            if (poke && k == 1) begin start = 1'b1; cok = 16'h0; onset = 16'hFFFF; end
            if (poke && k == 2) start = 1'b0;
            check(done == (k == n), {tag, " R9 done cycle"}, int'(done), int'(k == n));
            check(busy == (k < n),  {tag, " R9 busy"},       int'(busy), int'(k < n));
            if (k == n) begin
                check(sel == esel, {tag, " select vs model"}, sel, esel);
                uni = '0; sub = 1'b1;
                for (int r = 0; r < 16; r++) if (sel[r]) begin
                    uni |= cube_cov(v[r*4 +: 4], c[r*4 +: 4]);
                    if ((cube_cov(v[r*4 +: 4], c[r*4 +: 4]) & ~on) != '0) sub = 1'b0;
                end
                check(uni == (on & reach), {tag, " R8 exact cover"}, uni, on & reach);
                check(sub, {tag, " R8 no cube outside on-set"}, int'(sub), 1);
                check((sel & ~ok) == '0, {tag, " R2 invalid never selected"}, sel & ~ok, 0);
                got = sel;
            end
            @(negedge clk);
        end
        check(!done && sel == esel, {tag, " R8 pulse ends, select held"}, sel, esel);
    endtask

    // Textbook primes A..G, variable 3 is the leftmost literal.
    localparam logic [3:0] AV = 4'b0000, AC = 4'b1100;
    localparam logic [3:0] BV = 4'b0010, BC = 4'b0110;
    localparam logic [3:0] CV = 4'b0000, CC = 4'b0101;
    localparam logic [3:0] DV = 4'b0001, DC = 4'b1011;
    localparam logic [3:0] EV = 4'b0101, EC = 4'b0111;
    localparam logic [3:0] FV = 4'b1011, FC = 4'b1011;
    localparam logic [3:0] GV = 4'b1101, GC = 4'b1101;
    localparam logic [15:0] EX_ON = 16'b1010_1101_0010_1111;

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] v, c;
        logic [15:0] got;
        rst_n = 1'b0; start = 1'b0; cval = '0; ccare = '0; cok = '0; onset = '0;
        repeat (3) @(negedge clk);
        check(!busy && !done && sel == '0, "R1 reset state", {busy, done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && sel == '0, "R1 after release", {busy, done}, 0);

        // Essential, cyclic break, row deletions: expect A,C,E,F
        v = {36'h0, GV, FV, EV, DV, CV, BV, AV};
        c = {36'h0, GC, FC, EC, DC, CC, BC, AC};
        run_case("example R4 R5 R7", v, c, 16'h007F, EX_ON, 1'b0, got);
        check(got == 16'h0035, "R4 R7 four-cube cover", got, 16'h0035);
        check($countones(got) == 4, "R4 cover size", $countones(got), 4);

        // Start while busy is ignored
        run_case("restart R10", v, c, 16'h007F, EX_ON, 1'b1, got);
        check(got == 16'h0035, "R10 start ignored", got, 16'h0035);

        // Rank differs from index
        v = {36'h0, CV, BV, AV, GV, FV, EV, DV};
        c = {36'h0, CC, BC, AC, GC, FC, EC, DC};
        run_case("permuted R7", v, c, 16'h007F, EX_ON, 1'b0, got);
        check(got == 16'h0056, "R7 cheapest row first", got, 16'h0056);

        // Invalid covering cube at index 7
        v = {32'h0, 4'h0, GV, FV, EV, DV, CV, BV, AV};
        c = {32'h0, 4'h0, GC, FC, EC, DC, CC, BC, AC};
        run_case("invalid R2", v, c, 16'h007F, EX_ON, 1'b0, got);
        check(got == 16'h0035, "R2 invalid cube ignored", got, 16'h0035);

        // Uncoverable minterm 4 is dropped
        run_case("uncoverable R3", v, c, 16'h007F, EX_ON | 16'h0010, 1'b0, got);
        check(got == 16'h0035, "R3 uncoverable dropped", got, 16'h0035);

        // Empty on-set
        run_case("empty R3", v, c, 16'h007F, 16'h0000, 1'b0, got);
        check(got == 16'h0000, "R3 empty selection", got, 0);

        // One cube covering everything at index 3
        v = {48'h0, 4'h0, CV, BV, AV};
        c = {48'h0, 4'h0, CC, BC, AC};
        run_case("full R4", v, c, 16'h000F, 16'hFFFF, 1'b0, got);
        check(got == 16'h0008, "R4 single essential", got, 16'h0008);

        // Random lists: column and row dominance, longer cyclic chains
        for (int t = 0; t < 40; t++) begin
            logic [15:0] ok, on;
            v = '0; c = '0; ok = '0; on = '0;
            for (int r = 0; r < 16; r++) begin
                logic [3:0] cc, vv;
                cc = 4'($urandom);
                vv = 4'($urandom) & cc;
                c[r*4 +: 4] = cc; v[r*4 +: 4] = vv;
                ok[r] = ($urandom % 5) != 0;
                if (ok[r]) on |= cube_cov(vv, cc);
            end
            run_case("random R5 R6 R7", v, c, ok, on, 1'b0, got);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule